// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address. It reads one or two 32-bit descriptors from a translation table in memory. A request is accepted only while the walker is idle. The walker then reads the first-level descriptor, at an address built from the table base and the top twelve virtual address bits. The low two bits of that descriptor decide what happens next. A section, or an invalid entry, ends the walk after a single read. A coarse or fine table pointer leads to one more read, whose result resolves to a large, small or tiny page or to a fault.

The memory side is a single-word read port. The walker holds a request and its address until the memory answers with ready, and it takes the read data in that same cycle. Each request ends with a one-cycle done pulse. The physical address, the resolved page size, the permission bits, the domain and the fault status are all presented with that pulse, and they hold their values until the next walk completes. Permission and domain checking, caching of translations and bus protocol conversion belong to other blocks.

Top module: `ptw_walker`

## Requirements
- R1: During and right after reset, `done_o`, `fault_o` and `mem_req_o` are low, `req_ready_o` is high, and all result outputs are zero.
- R2: A request is accepted only at a clock edge where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` stays low from acceptance until the done pulse. A `req_valid_i` raised while busy is ignored and changes neither the result nor the number of reads.
- R3: The first read goes out in the cycle after acceptance, at address {table base [31:14], VA[31:20], 2'b00}. Base bits [13:0] have no effect.
- R4: Each read holds `mem_req_o` high with a stable address until a cycle with `mem_ready_i` high. The read data is taken in that cycle, and any number of wait cycles is allowed.
- R5: First-level descriptor bits [1:0] select the walk: 00 fault, 01 coarse pointer, 10 section, 11 fine pointer.
- R6: A section finishes after one read. Physical address = {desc[31:20], VA[19:0]}, size code 1, `ap_o` = {6'b0, desc[11:10]}, `domain_o` = desc[8:5].
- R7: For a coarse pointer, the second read address is {desc[31:10], VA[19:12], 2'b00}. For a fine pointer it is {desc[31:12], VA[19:10], 2'b00}.
- R8: Second-level descriptor bits [1:0] give: 01 large page (size code 2, PA {d[31:16], VA[15:0]}), 10 small page (code 3, PA {d[31:12], VA[11:0]}) and 11 tiny page (code 4, PA {d[31:10], VA[9:0]}). Large and small pages give `ap_o` = d[11:4] and tiny pages give {6'b0, d[5:4]}. `domain_o` is the first-level desc[8:5].
- R9: A first-level fault ends after one read with `fault_o` high, status 4'b0101, `domain_o` 0, page size code 0, PA 0, and `fault_addr_o` set to the request VA.
- R10: A second-level fault ends with `fault_o` high, status 4'b0111, `domain_o` taken from the first-level descriptor, size code 0, and `fault_addr_o` set to the request VA.
- R11: `done_o` goes high for exactly one cycle per accepted request, in the cycle after the final read's ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ttb_i | input | 32 | Translation table base, bits [31:14] used |
| req_valid_i | input | 1 | Translation request |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_ready_o | output | 1 | Walker idle, request accepted when valid |
| mem_req_o | output | 1 | Descriptor read request |
| mem_addr_o | output | 32 | Descriptor read address |
| mem_rdata_i | input | 32 | Descriptor read data |
| mem_ready_i | input | 1 | Read data valid, completes the read |
| done_o | output | 1 | One-cycle completion pulse |
| pa_o | output | 32 | Physical address |
| page_size_o | output | 3 | 0 none, 1 section, 2 large, 3 small, 4 tiny |
| ap_o | output | 8 | Access permission bits of the final descriptor |
| domain_o | output | 4 | Domain field of the first-level descriptor |
| fault_o | output | 1 | Walk ended in a translation fault |
| fault_status_o | output | 4 | Fault status code |
| fault_addr_o | output | 32 | Virtual address of the last faulting walk |

## Verification
The first read address is due one cycle after the accepting edge. Every later read is due in the cycle after the previous ready. The done pulse and all result fields are due exactly one cycle after the last ready. The bench's memory model drives ready and data on the falling edge and records the cycle number of each ready. Each scenario task samples on falling edges, checks that done rises exactly one cycle after the recorded ready, and checks that it has dropped one cycle later. The read addresses are compared in the order they were issued, and a request raised while the walker is busy is followed by a check of the read count and of `mem_req_o` after the done pulse.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int AW          = 32;
  localparam int L1_IDX_W    = 12;
  localparam int TTB_KEEP_W  = AW - L1_IDX_W - 2;
  localparam int SEC_OFS_W   = AW - L1_IDX_W;
  localparam int LARGE_OFS_W = 16;
  localparam int SMALL_OFS_W = 12;
  localparam int TINY_OFS_W  = 10;
  localparam int AP_W        = 8;
  localparam int DOM_W       = 4;
  localparam int FS_W        = 4;
  localparam int DOM_LSB     = 5;
  localparam int SEC_AP_LSB  = 10;
  localparam int PG_AP_LSB   = 4;

  typedef enum logic [1:0] {
    L1_FAULT = 2'b00, L1_COARSE = 2'b01, L1_SECTION = 2'b10, L1_FINE = 2'b11
  } l1_kind_e;

  typedef enum logic [1:0] {
    L2_FAULT = 2'b00, L2_LARGE = 2'b01, L2_SMALL = 2'b10, L2_TINY = 2'b11
  } l2_kind_e;

  typedef enum logic [2:0] {
    PG_NONE = 3'd0, PG_SECTION = 3'd1, PG_LARGE = 3'd2, PG_SMALL = 3'd3, PG_TINY = 3'd4
  } pg_size_e;

  localparam logic [FS_W-1:0] FS_SECTION_XLATE = 4'b0101;
  localparam logic [FS_W-1:0] FS_PAGE_XLATE    = 4'b0111;

  typedef struct packed {
    logic [AW-1:0]    pa;
    pg_size_e         size;
    logic [AP_W-1:0]  ap;
    logic [DOM_W-1:0] dom;
    logic             fault;
    logic [FS_W-1:0]  status;
  } walk_res_t;

  // upper bits from base, low ofs_w bits from offset
  function automatic logic [AW-1:0] splice(input logic [AW-1:0] base,
                                           input logic [AW-1:0] ofs,
                                           input int ofs_w);
    logic [AW-1:0] m;
    m = {AW{1'b1}} << ofs_w;
    return (base & m) | (ofs & ~m);
  endfunction
endpackage

// File: rtl/ptw_l1_dec.sv
module ptw_l1_dec
  import ptw_pkg::*;
(
  input  logic [AW-1:0] desc_i,
  input  logic [AW-1:0] va_i,
  output logic          need_l2_o,
  output logic [AW-1:0] l2_addr_o,
  output walk_res_t     res_o
);
  l1_kind_e kind;
  assign kind = l1_kind_e'(desc_i[1:0]);

  always_comb begin
    need_l2_o = 1'b0;
    l2_addr_o = '0;
    res_o     = '0;
    unique case (kind)
      L1_SECTION: begin
        res_o.pa   = splice(desc_i, va_i, SEC_OFS_W);
        res_o.size = PG_SECTION;
        res_o.ap   = AP_W'(desc_i[SEC_AP_LSB +: 2]);
        res_o.dom  = desc_i[DOM_LSB +: DOM_W];
      end
      L1_COARSE: begin
        need_l2_o = 1'b1;
        l2_addr_o = {desc_i[AW-1:TINY_OFS_W], va_i[SEC_OFS_W-1:SMALL_OFS_W], 2'b00};
      end
      L1_FINE: begin
        need_l2_o = 1'b1;
        l2_addr_o = {desc_i[AW-1:SMALL_OFS_W], va_i[SEC_OFS_W-1:TINY_OFS_W], 2'b00};
      end
      default: begin
        res_o.size   = PG_NONE;
        res_o.fault  = 1'b1;
        res_o.status = FS_SECTION_XLATE;
      end
    endcase
  end
endmodule

// File: rtl/ptw_l2_dec.sv
module ptw_l2_dec
  import ptw_pkg::*;
(
  input  logic [AW-1:0]    desc_i,
  input  logic [AW-1:0]    va_i,
  input  logic [DOM_W-1:0] dom_i,
  output walk_res_t        res_o
);
  l2_kind_e kind;
  assign kind = l2_kind_e'(desc_i[1:0]);

  always_comb begin
    res_o     = '0;
    res_o.dom = dom_i;
    unique case (kind)
      L2_LARGE: begin
        res_o.pa   = splice(desc_i, va_i, LARGE_OFS_W);
        res_o.size = PG_LARGE;
        res_o.ap   = desc_i[PG_AP_LSB +: AP_W];
      end
      L2_SMALL: begin
        res_o.pa   = splice(desc_i, va_i, SMALL_OFS_W);
        res_o.size = PG_SMALL;
        res_o.ap   = desc_i[PG_AP_LSB +: AP_W];
      end
      L2_TINY: begin
        res_o.pa   = splice(desc_i, va_i, TINY_OFS_W);
        res_o.size = PG_TINY;
        res_o.ap   = AP_W'(desc_i[PG_AP_LSB +: 2]);
      end
      default: begin
        res_o.size   = PG_NONE;
        res_o.fault  = 1'b1;
        res_o.status = FS_PAGE_XLATE;
      end
    endcase
  end
endmodule

// File: rtl/ptw_seq.sv
module ptw_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic mem_ready_i,
  input  logic need_l2_i,
  output logic idle_o,
  output logic accept_o,
  output logic fetch_o,
  output logic in_l2_o,
  output logic l1_take_o,
  output logic finish_l1_o,
  output logic finish_l2_o
);
  typedef enum logic [1:0] {S_IDLE, S_L1, S_L2} st_e;
  st_e st_q, st_d;

  always_comb begin
    st_d        = st_q;
    accept_o    = 1'b0;
    l1_take_o   = 1'b0;
    finish_l1_o = 1'b0;
    finish_l2_o = 1'b0;
    unique case (st_q)
      S_IDLE: if (req_valid_i) begin
        accept_o = 1'b1;
        st_d     = S_L1;
      end
      S_L1: if (mem_ready_i) begin
        if (need_l2_i) begin
          l1_take_o = 1'b1;
          st_d      = S_L2;
        end else begin
          finish_l1_o = 1'b1;
          st_d        = S_IDLE;
        end
      end
      S_L2: if (mem_ready_i) begin
        finish_l2_o = 1'b1;
        st_d        = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= S_IDLE;
    else         st_q <= st_d;
  end

  assign idle_o  = (st_q == S_IDLE);
  assign fetch_o = (st_q != S_IDLE);
  assign in_l2_o = (st_q == S_L2);
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [31:0]   ttb_i,
  input  logic          req_valid_i,
  input  logic [31:0]   req_vaddr_i,
  output logic          req_ready_o,
  output logic          mem_req_o,
  output logic [31:0]   mem_addr_o,
  input  logic [31:0]   mem_rdata_i,
  input  logic          mem_ready_i,
  output logic          done_o,
  output logic [31:0]   pa_o,
  output logic [2:0]    page_size_o,
  output logic [7:0]    ap_o,
  output logic [3:0]    domain_o,
  output logic          fault_o,
  output logic [3:0]    fault_status_o,
  output logic [31:0]   fault_addr_o
);
  logic accept, in_l2, l1_take, fin_l1, fin_l2, need_l2;
  logic [AW-1:0]         l2_addr_d;
  walk_res_t             l1_res, l2_res;

  logic [AW-1:0]         va_q;
  logic [TTB_KEEP_W-1:0] ttb_q;
  logic [AW-1:0]         l2_addr_q;
  logic [DOM_W-1:0]      dom_q;
  walk_res_t             res_q;
  logic                  done_q;
  logic [AW-1:0]         fault_addr_q;

  ptw_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .mem_ready_i (mem_ready_i),
    .need_l2_i   (need_l2),
    .idle_o      (req_ready_o),
    .accept_o    (accept),
    .fetch_o     (mem_req_o),
    .in_l2_o     (in_l2),
    .l1_take_o   (l1_take),
    .finish_l1_o (fin_l1),
    .finish_l2_o (fin_l2)
  );

  ptw_l1_dec u_l1 (
    .desc_i    (mem_rdata_i),
    .va_i      (va_q),
    .need_l2_o (need_l2),
    .l2_addr_o (l2_addr_d),
    .res_o     (l1_res)
  );

  ptw_l2_dec u_l2 (
    .desc_i (mem_rdata_i),
    .va_i   (va_q),
    .dom_i  (dom_q),
    .res_o  (l2_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      va_q         <= '0;
      ttb_q        <= '0;
      l2_addr_q    <= '0;
      dom_q        <= '0;
      res_q        <= '0;
      done_q       <= 1'b0;
      fault_addr_q <= '0;
    end else begin
      done_q <= fin_l1 | fin_l2;
      if (accept) begin
        va_q  <= req_vaddr_i;
        ttb_q <= ttb_i[AW-1 -: TTB_KEEP_W];
      end
      if (l1_take) begin
        l2_addr_q <= l2_addr_d;
        dom_q     <= mem_rdata_i[DOM_LSB +: DOM_W];
      end
      if (fin_l1 || fin_l2) begin
        res_q <= fin_l2 ? l2_res : l1_res;
        if (fin_l2 ? l2_res.fault : l1_res.fault) fault_addr_q <= va_q;
      end
    end
  end

  assign mem_addr_o     = in_l2 ? l2_addr_q
                                : {ttb_q, va_q[AW-1 -: L1_IDX_W], 2'b00};
  assign done_o         = done_q;
  assign pa_o           = res_q.pa;
  assign page_size_o    = res_q.size;
  assign ap_o           = res_q.ap;
  assign domain_o       = res_q.dom;
  assign fault_o        = res_q.fault;
  assign fault_status_o = res_q.status;
  assign fault_addr_o   = fault_addr_q;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] ttb_i,
  input logic        req_valid_i,
  input logic [31:0] req_vaddr_i,
  input logic        req_ready_o,
  input logic        mem_req_o,
  input logic [31:0] mem_addr_o,
  input logic        mem_ready_i,
  input logic        done_o,
  input logic [3:0]  domain_o,
  input logic        fault_o,
  input logic [3:0]  fault_status_o,
  input logic [31:0] fault_addr_o
);
  logic [31:0] va_c;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) va_c <= '0;
    else if (req_valid_i && req_ready_o) va_c <= req_vaddr_i;
  end

  AST_IDLE_NO_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_o); // R2

  AST_BUSY_UNTIL_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o); // R2

  AST_L1_FETCH_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> mem_req_o &&
      mem_addr_o == {$past(ttb_i[31:14]), $past(req_vaddr_i[31:20]), 2'b00}); // R3

  AST_FETCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o)); // R4

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11

  AST_DONE_AFTER_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(mem_req_o && mem_ready_i)); // R11

  AST_L1_FAULT_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fault_o && fault_status_o == 4'b0101 |-> domain_o == 4'd0); // R9

  AST_FAULT_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fault_o |-> fault_status_o == 4'b0101 || fault_status_o == 4'b0111); // R10

  AST_FAULT_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fault_o |-> fault_addr_o == va_c); // R9
endmodule

bind ptw_walker ptw_walker_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .ttb_i          (ttb_i),
  .req_valid_i    (req_valid_i),
  .req_vaddr_i    (req_vaddr_i),
  .req_ready_o    (req_ready_o),
  .mem_req_o      (mem_req_o),
  .mem_addr_o     (mem_addr_o),
  .mem_ready_i    (mem_ready_i),
  .done_o         (done_o),
  .domain_o       (domain_o),
  .fault_o        (fault_o),
  .fault_status_o (fault_status_o),
  .fault_addr_o   (fault_addr_o)
);

// File: tb/ptw_walker_tb_top.sv
`timescale 1ns/1ps
module ptw_walker_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] ttb_i = '0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_vaddr_i = '0;
  logic        req_ready_o, mem_req_o, done_o, fault_o;
  logic [31:0] mem_addr_o, pa_o, fault_addr_o;
  logic [31:0] mem_rdata_i = '0;
  logic        mem_ready_i = 1'b0;
  logic [2:0]  page_size_o;
  logic [7:0]  ap_o;
  logic [3:0]  domain_o, fault_status_o;

  always #5 clk_i = ~clk_i;

  ptw_walker dut_i (.*);

  int checks = 0, fails = 0;
  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  // memory model
  logic [31:0] tbl_a [8];
  logic [31:0] tbl_d [8];
  int          tbl_n = 0;
  int          lat = 0, wcnt = 0, fc = 0, ready_cyc = 0;
  logic [31:0] fa [4];

  function automatic logic [31:0] lookup(input logic [31:0] a);
    for (int i = 0; i < tbl_n; i++) if (tbl_a[i] == a) return tbl_d[i];
    return 32'h0;
  endfunction

  task automatic put(input logic [31:0] a, input logic [31:0] d);
    tbl_a[tbl_n] = a; tbl_d[tbl_n] = d; tbl_n++;
  endtask

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      mem_ready_i = 1'b0; wcnt = 0;
    end else if (mem_ready_i) begin
      mem_ready_i = 1'b0; wcnt = 0;
    end else if (mem_req_o) begin
      if (wcnt >= lat) begin
        mem_ready_i = 1'b1;
        mem_rdata_i = lookup(mem_addr_o);
        if (fc < 4) fa[fc] = mem_addr_o;
        fc++;
        ready_cyc = cyc;
      end else wcnt++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic launch(input logic [31:0] va, input int l);
    @(negedge clk_i);
    lat = l; fc = 0;
    req_valid_i = 1'b1; req_vaddr_i = va;
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done_o && n < 60) begin @(negedge clk_i); n++; end
    check(done_o === 1'b1, req, 32'(done_o), 32'd1);
    check(cyc == ready_cyc + 1, "R11 done timing", cyc, ready_cyc + 1);
  endtask

  task automatic after_done();
    @(negedge clk_i);
    check(done_o === 1'b0, "R11 single pulse", 32'(done_o), 32'd0);
  endtask

  task automatic expect_res(input string req, input logic [31:0] pa, input int sz,
                            input logic [7:0] ap, input logic [3:0] dom, input bit flt,
                            input logic [3:0] st);
    check(pa_o == pa, {req, " pa"}, pa_o, pa);
    check(page_size_o == 3'(sz), {req, " size"}, 32'(page_size_o), sz);
    check(ap_o == ap, {req, " ap"}, 32'(ap_o), 32'(ap));
    check(domain_o == dom, {req, " domain"}, 32'(domain_o), 32'(dom));
    check(fault_o == flt, {req, " fault"}, 32'(fault_o), 32'(flt));
    if (flt) check(fault_status_o == st, {req, " status"}, 32'(fault_status_o), 32'(st));
  endtask

  task automatic t_reset();
    check(done_o === 1'b0 && fault_o === 1'b0, "R1 done/fault", {done_o, fault_o}, 0);
    check(mem_req_o === 1'b0, "R1 mem_req", 32'(mem_req_o), 0);
    check(req_ready_o === 1'b1, "R1 ready", 32'(req_ready_o), 1);
    check(pa_o === 32'h0 && fault_addr_o === 32'h0, "R1 results", pa_o, 0);
  endtask

  task automatic t_section(input logic [31:0] base, input int l);
    logic [31:0] va = 32'h1234_5678;
    logic [31:0] d1 = 32'hABC0_0CA2; // section, ap 11, domain 5
    tbl_n = 0;
    ttb_i = base;
    put({base[31:14], va[31:20], 2'b00}, d1);
    launch(va, l);
    wait_done("R6 section done");
    check(fc == 1, "R6 single read", fc, 1);
    check(fa[0] == {base[31:14], va[31:20], 2'b00}, "R3 l1 address", fa[0],
          {base[31:14], va[31:20], 2'b00});
    expect_res("R6 R5", {d1[31:20], va[19:0]}, 1, {6'b0, d1[11:10]}, d1[8:5], 0, 0);
    after_done();
  endtask

  task automatic t_two_level(input string req, input logic [31:0] va, input logic [31:0] d1,
                             input logic [31:0] d2, input int l, input int sz,
                             input bit flt);
    logic [31:0] a2, pa;
    logic [7:0]  ap;
    tbl_n = 0;
    ttb_i = 32'h0004_0000;
    a2 = (d1[1:0] == 2'b01) ? {d1[31:10], va[19:12], 2'b00} : {d1[31:12], va[19:10], 2'b00};
    put({ttb_i[31:14], va[31:20], 2'b00}, d1);
    if (!flt) put(a2, d2);
    case (sz)
      2: begin pa = {d2[31:16], va[15:0]}; ap = d2[11:4]; end
      3: begin pa = {d2[31:12], va[11:0]}; ap = d2[11:4]; end
      4: begin pa = {d2[31:10], va[9:0]};  ap = {6'b0, d2[5:4]}; end
      default: begin pa = 0; ap = 0; end
    endcase
    launch(va, l);
    wait_done({req, " done"});
    check(fc == 2, "R7 two reads", fc, 2);
    check(fa[1] == a2, "R7 l2 address", fa[1], a2);
    expect_res(req, pa, sz, ap, d1[8:5], flt, 4'b0111);
    if (flt) check(fault_addr_o == va, "R10 fault addr", fault_addr_o, va);
    after_done();
  endtask

  task automatic t_l1_fault();
    logic [31:0] va = 32'h0040_0ABC;
    tbl_n = 0;
    ttb_i = 32'h0004_0000;
    launch(va, 1);
    wait_done("R9 done");
    check(fc == 1, "R9 single read", fc, 1);
    expect_res("R9", 32'h0, 0, 8'h0, 4'h0, 1, 4'b0101);
    check(fault_addr_o == va, "R9 fault addr", fault_addr_o, va);
    after_done();
  endtask

  task automatic t_busy_ignored();
    logic [31:0] va = 32'h1234_5678;
    logic [31:0] d1 = 32'h5550_0422;
    tbl_n = 0;
    ttb_i = 32'h0004_0000;
    put({ttb_i[31:14], va[31:20], 2'b00}, d1);
    launch(va, 4);
    @(negedge clk_i);
    check(req_ready_o === 1'b0, "R2 busy not ready", 32'(req_ready_o), 0);
    req_valid_i = 1'b1; req_vaddr_i = 32'hFFF0_0000;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    wait_done("R2 done");
    check(pa_o == {d1[31:20], va[19:0]}, "R2 ignored request pa", pa_o, {d1[31:20], va[19:0]});
    check(fc == 1, "R2 read count", fc, 1);
    after_done();
    repeat (3) @(negedge clk_i);
    check(mem_req_o === 1'b0 && fc == 1, "R2 no extra walk", fc, 1);
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_section(32'h0004_0000, 0);
    t_section(32'h0008_3FFF, 3);   // R3 base low bits ignored, R4 waits
    t_two_level("R8 small coarse", 32'h0015_6ABC, 32'h0008_0461, 32'h7777_7E42, 2, 3, 0);
    t_two_level("R8 large coarse", 32'h0025_ABCD, 32'h0009_0001, 32'h1234_05A1, 0, 2, 0);
    t_two_level("R8 tiny fine",    32'h0036_7E5F, 32'h000A_1123, 32'hCAFE_F423, 1, 4, 0);
    t_two_level("R8 small fine",   32'h0046_1234, 32'h000B_21E3, 32'h3456_7B32, 5, 3, 0);
    t_l1_fault();
    t_two_level("R10 l2 fault",    32'h0015_0000, 32'h0008_0461, 32'h0, 1, 0, 1);
    t_busy_ignored();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk_i);
        fails++; checks++;
        $display("FAIL watchdog (R11): actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule